// File: doc/BRIEF.md
# System Exception Control Register File

A word-wide, memory-mapped register block through which software drives the system-level exceptions of a processor core. A write to the control word raises single-cycle command pulses that set or clear the pending state of the non-maskable interrupt, the deferred service-call exception and the tick-timer exception. Where one write asks for both set and clear, the set wins. The block also stores the vector table base, the priority bytes of the system handlers and the enables of three fault handlers. A key-protected reset-control word produces a one-cycle reset request.

The exception logic sits outside the block. It supplies the active and pending flags of each system exception and the number of the highest pending vector. The register file only presents these through its read path. It does no arbitration, no vectoring and no fault capture. Reads are combinational on the offset. Writes take effect at the clock edge on which `wr_en_i` is high, and every command pulse is high during the following cycle.

Top module: `sysexc_regfile`

## Requirements
- R1: A write to offset 0xD04 with bit 31 set raises `nmi_set_o` for exactly one cycle, in the cycle after the write edge.
- R2: A write to 0xD04 with bit 28 set raises `sv_set_o`. Bit 27 raises `sv_clr_o` only when bit 28 is 0 in the same write. The two pulses are never high together.
- R3: A write to 0xD04 with bit 26 set raises `tk_set_o`. Bit 25 raises `tk_clr_o` only when bit 26 is 0 in the same write. The two pulses are never high together.
- R4: A write to 0xD08 stores the data ANDed with 0xFFFFFF80 into `vbase_o`, and a read of 0xD08 returns the stored value.
- R5: A write to 0xD0C with bit 2 set raises `rst_req_o` for one cycle only if bits 31:16 equal 0x05FA. Without that key the write has no effect. A read of 0xD0C returns 0.
- R6: Offsets 0xD18, 0xD1C and 0xD20 each hold four priority bytes, byte n of the word at bits 8n+7:8n. Register k, byte n appears on `prio_o[32k+8n +: 8]`, and the register reads back as written.
- R7: A read of 0xD24 maps `act_i` bits 0..6 (mem, bus, usage, svc, debug, deferred-call, tick) to bits 0, 1, 3, 7, 8, 10, 11. It maps `pend_i` bits 0..3 (usage, mem, bus, svc) to bits 12, 13, 14, 15.
- R8: A write to 0xD24 stores bits 18:16 into `fault_en_o` (bit 0 mem, 1 bus, 2 usage), and these read back at bits 18:16. All other bits of that write have no effect.
- R9: A read of 0xD04 returns `pend_vec_i` at bits 12 upward, plus the pending flags `sys_pend_i[2]` (NMI) at bit 31, `sys_pend_i[1]` (deferred call) at bit 28 and `sys_pend_i[0]` (tick) at bit 26. All other bits are 0.
- R10: A read of any other offset returns 0, and a write to it changes no output and raises no pulse.
- R11: After synchronous reset, all pulses, `vbase_o`, `prio_o` and `fault_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| act_i | input | 7 | Active flags from exception logic |
| pend_i | input | 4 | Fault/service-call pending flags |
| sys_pend_i | input | 3 | Pending flags {NMI, deferred call, tick} |
| pend_vec_i | input | VEC_W | Highest pending vector number |
| nmi_set_o | output | 1 | Pulse: set NMI pending |
| sv_set_o | output | 1 | Pulse: set deferred-call pending |
| sv_clr_o | output | 1 | Pulse: clear deferred-call pending |
| tk_set_o | output | 1 | Pulse: set tick pending |
| tk_clr_o | output | 1 | Pulse: clear tick pending |
| rst_req_o | output | 1 | Pulse: system reset request |
| fault_en_o | output | 3 | Fault handler enables {usage, bus, mem} |
| prio_o | output | 32*PRIO_REGS | System handler priority bytes |
| vbase_o | output | 32 | Vector table base |

## Verification
The bench writes set and clear bits together, to confirm that the set has precedence. A design that let both through would emit contradictory pulses in the same cycle. It writes the reset bit with a wrong key and with the right key, so a missing key compare shows up as a spurious reset request. All-ones data goes to the vector base, to the handler control word and to an unmapped offset. This exposes a wrong mask, writable status bits and aliasing decodes. Distinct bit patterns on the active and pending inputs catch any swapped bit in the scattered status mapping.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    localparam logic [11:0] A_ICTL  = 12'hD04;
    localparam logic [11:0] A_VBASE = 12'hD08;
    localparam logic [11:0] A_RSTC  = 12'hD0C;
    localparam logic [11:0] A_PRIO0 = 12'hD18;
    localparam logic [11:0] A_HCS   = 12'hD24;

    localparam logic [15:0] RST_KEY    = 16'h05FA;
    localparam logic [31:0] VBASE_MASK = 32'hFFFF_FF80;

    typedef struct packed {
        logic nmi_set;
        logic sv_set;
        logic sv_clr;
        logic tk_set;
        logic tk_clr;
        logic rst_req;
    } exc_cmd_t;

    // sv_tk = {sv_set_bit, sv_clr_bit, tk_set_bit, tk_clr_bit}
    function automatic exc_cmd_t decode_cmd(input logic ictl_wr, input logic rstc_wr,
                                            input logic nmi_b, input logic [3:0] sv_tk,
                                            input logic [15:0] key, input logic rst_b);
        exc_cmd_t c;
        c = '0;
        if (ictl_wr) begin
            c.nmi_set = nmi_b;
            c.sv_set  = sv_tk[3];
            c.sv_clr  = sv_tk[2] & ~sv_tk[3];
            c.tk_set  = sv_tk[1];
            c.tk_clr  = sv_tk[0] & ~sv_tk[1];
        end
        if (rstc_wr && key == RST_KEY)
            c.rst_req = rst_b;
        return c;
    endfunction

    function automatic logic [31:0] pack_hcs(input logic [6:0] act, input logic [3:0] pend,
                                             input logic [2:0] en);
        logic [31:0] w;
        w = '0;
        w[0]  = act[0];
        w[1]  = act[1];
        w[3]  = act[2];
        w[7]  = act[3];
        w[8]  = act[4];
        w[10] = act[5];
        w[11] = act[6];
        w[15:12] = {pend[3], pend[2], pend[1], pend[0]};
        w[18:16] = en;
        return w;
    endfunction

endpackage

// File: rtl/sysexc_cmd_gen.sv
module sysexc_cmd_gen
    import sysexc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ictl_wr,
    input  logic        rstc_wr,
    input  logic        nmi_b,
    input  logic [3:0]  sv_tk,
    input  logic [15:0] key,
    input  logic        rst_b,
    output exc_cmd_t    cmd_o
);
    exc_cmd_t cmd_d;

    always_comb cmd_d = decode_cmd(ictl_wr, rstc_wr, nmi_b, sv_tk, key, rst_b);

    always_ff @(posedge clk) begin
        if (rst) cmd_o <= '0;
        else     cmd_o <= cmd_d;
    end
endmodule

// File: rtl/sysexc_store.sv
module sysexc_store
    import sysexc_pkg::*;
#(
    parameter int PRIO_REGS = 3,
    localparam int PRIO_W = 32 * PRIO_REGS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vb_wr,
    input  logic                 hcs_wr,
    input  logic [PRIO_REGS-1:0] prio_wr,
    input  logic [31:0]          wdata,
    output logic [31:0]          vbase,
    output logic [2:0]           fault_en,
    output logic [PRIO_W-1:0]    prio
);
    always_ff @(posedge clk) begin
        if (rst)        vbase <= '0;
        else if (vb_wr) vbase <= wdata & VBASE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)         fault_en <= '0;
        else if (hcs_wr) fault_en <= wdata[18:16];
    end

    for (genvar k = 0; k < PRIO_REGS; k++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)             prio[32*k +: 32] <= '0;
            else if (prio_wr[k]) prio[32*k +: 32] <= wdata;
        end
    end
endmodule

// File: rtl/sysexc_rd_mux.sv
module sysexc_rd_mux
    import sysexc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int VEC_W     = 9,
    parameter int PRIO_REGS = 3,
    localparam int PRIO_W = 32 * PRIO_REGS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [6:0]        act,
    input  logic [3:0]        pend,
    input  logic [2:0]        sys_pend,
    input  logic [VEC_W-1:0]  pend_vec,
    input  logic [31:0]       vbase,
    input  logic [2:0]        fault_en,
    input  logic [PRIO_W-1:0] prio,
    output logic [31:0]       rdata
);
    logic [31:0] ictl_word;

    always_comb begin
        ictl_word = '0;
        ictl_word[12 +: VEC_W] = pend_vec;
        ictl_word[31] = sys_pend[2];
        ictl_word[28] = sys_pend[1];
        ictl_word[26] = sys_pend[0];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_ICTL))  rdata = ictl_word;
        if (addr == ADDR_W'(A_VBASE)) rdata = vbase;
        if (addr == ADDR_W'(A_HCS))   rdata = pack_hcs(act, pend, fault_en);
        for (int k = 0; k < PRIO_REGS; k++)
            if (addr == ADDR_W'(32'(A_PRIO0) + 32'(4 * k))) rdata = prio[32*k +: 32];
    end
endmodule

// File: rtl/sysexc_regfile.sv
module sysexc_regfile
    import sysexc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int VEC_W     = 9,
    parameter int PRIO_REGS = 3,
    localparam int PRIO_W = 32 * PRIO_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [6:0]        act_i,
    input  logic [3:0]        pend_i,
    input  logic [2:0]        sys_pend_i,
    input  logic [VEC_W-1:0]  pend_vec_i,
    output logic              nmi_set_o,
    output logic              sv_set_o,
    output logic              sv_clr_o,
    output logic              tk_set_o,
    output logic              tk_clr_o,
    output logic              rst_req_o,
    output logic [2:0]        fault_en_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic [31:0]       vbase_o
);
    logic                 ictl_wr, rstc_wr, vb_wr, hcs_wr;
    logic [PRIO_REGS-1:0] prio_wr;
    exc_cmd_t             cmd;

    assign ictl_wr = wr_en_i && addr_i == ADDR_W'(A_ICTL);
    assign rstc_wr = wr_en_i && addr_i == ADDR_W'(A_RSTC);
    assign vb_wr   = wr_en_i && addr_i == ADDR_W'(A_VBASE);
    assign hcs_wr  = wr_en_i && addr_i == ADDR_W'(A_HCS);

    for (genvar k = 0; k < PRIO_REGS; k++) begin : g_pdec
        assign prio_wr[k] = wr_en_i && addr_i == ADDR_W'(32'(A_PRIO0) + 32'(4 * k));
    end

    sysexc_cmd_gen u_cmd (
        .clk     (clk),
        .rst     (rst),
        .ictl_wr (ictl_wr),
        .rstc_wr (rstc_wr),
        .nmi_b   (wdata_i[31]),
        .sv_tk   (wdata_i[28:25]),
        .key     (wdata_i[31:16]),
        .rst_b   (wdata_i[2]),
        .cmd_o   (cmd)
    );

    sysexc_store #(.PRIO_REGS(PRIO_REGS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .vb_wr    (vb_wr),
        .hcs_wr   (hcs_wr),
        .prio_wr  (prio_wr),
        .wdata    (wdata_i),
        .vbase    (vbase_o),
        .fault_en (fault_en_o),
        .prio     (prio_o)
    );

    sysexc_rd_mux #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .PRIO_REGS(PRIO_REGS)) u_rd (
        .addr     (addr_i),
        .act      (act_i),
        .pend     (pend_i),
        .sys_pend (sys_pend_i),
        .pend_vec (pend_vec_i),
        .vbase    (vbase_o),
        .fault_en (fault_en_o),
        .prio     (prio_o),
        .rdata    (rdata_o)
    );

    assign nmi_set_o = cmd.nmi_set;
    assign sv_set_o  = cmd.sv_set;
    assign sv_clr_o  = cmd.sv_clr;
    assign tk_set_o  = cmd.tk_set;
    assign tk_clr_o  = cmd.tk_clr;
    assign rst_req_o = cmd.rst_req;
endmodule

// File: rtl/sysexc_regfile_chk.sv
module sysexc_regfile_chk
    import sysexc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wdata_i,
    input logic [31:0]       rdata_o,
    input logic              nmi_set_o,
    input logic              sv_set_o,
    input logic              sv_clr_o,
    input logic              tk_set_o,
    input logic              tk_clr_o,
    input logic              rst_req_o,
    input logic [2:0]        fault_en_o,
    input logic [31:0]       vbase_o
);
    // R1
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_W'(A_ICTL) && wdata_i[31]) |=> nmi_set_o);

    // R2
    sv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sv_set_o && sv_clr_o));

    // R3
    tk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tk_set_o && tk_clr_o));

    // R4
    vbase_align_chk: assert property (@(posedge clk) disable iff (rst)
        vbase_o[6:0] == 7'd0);

    // R5
    rst_key_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> $past(wr_en_i && addr_i == ADDR_W'(A_RSTC)
                            && wdata_i[31:16] == RST_KEY && wdata_i[2]));

    // R8
    fault_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en_i && addr_i == ADDR_W'(A_HCS)) |-> $stable(fault_en_o));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADDR_W'(12'hD10)) |-> rdata_o == 32'd0);
endmodule

bind sysexc_regfile sysexc_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .nmi_set_o  (nmi_set_o),
    .sv_set_o   (sv_set_o),
    .sv_clr_o   (sv_clr_o),
    .tk_set_o   (tk_set_o),
    .tk_clr_o   (tk_clr_o),
    .rst_req_o  (rst_req_o),
    .fault_en_o (fault_en_o),
    .vbase_o    (vbase_o)
);

// File: tb/sysexc_regfile_tb_top.sv
`timescale 1ns/1ps
module sysexc_regfile_tb_top;
    localparam int ADDR_W = 12;
    localparam int VEC_W  = 9;
    localparam int PRIO_REGS = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en_i;
    logic [11:0] addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic [6:0]  act_i;
    logic [3:0]  pend_i;
    logic [2:0]  sys_pend_i;
    logic [8:0]  pend_vec_i;
    logic        nmi_set_o, sv_set_o, sv_clr_o, tk_set_o, tk_clr_o, rst_req_o;
    logic [2:0]  fault_en_o;
    logic [95:0] prio_o;
    logic [31:0] vbase_o;

    int n_run = 0;
    int n_fail = 0;
    logic [5:0] pulses;   // {nmi, sv_set, sv_clr, tk_set, tk_clr, rst_req}

    always #2 clk = ~clk;

    sysexc_regfile #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .PRIO_REGS(PRIO_REGS)) dut_i (.*);

    task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] cur_pulses();
        return {nmi_set_o, sv_set_o, sv_clr_o, tk_set_o, tk_clr_o, rst_req_o};
    endfunction

    // write: pulses captured in the cycle after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        pulses = cur_pulses();
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 12'h000; wdata_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'hD24, d);
        check("R11 hcs", d, 0);
        check("R11 vbase", vbase_o, 0);
        check("R11 prio", prio_o, 0);
        check("R11 fault_en", fault_en_o, 0);
        check("R11 pulses", cur_pulses(), 0);
    endtask

    task automatic t_nmi();
        wr(12'hD04, 32'h8000_0000);
        check("R1 pulse", pulses, 6'b100000);
        @(posedge clk); #1;
        check("R1 single", cur_pulses(), 0);
    endtask

    task automatic t_sv();
        wr(12'hD04, 32'h0800_0000);
        check("R2 clr only", pulses, 6'b001000);
        wr(12'hD04, 32'h1800_0000);
        check("R2 set wins", pulses, 6'b010000);
    endtask

    task automatic t_tick();
        wr(12'hD04, 32'h0200_0000);
        check("R3 clr only", pulses, 6'b000010);
        wr(12'hD04, 32'h0600_0000);
        check("R3 set wins", pulses, 6'b000100);
    endtask

    task automatic t_vbase();
        logic [31:0] d;
        wr(12'hD08, 32'hFFFF_FFFF);
        check("R4 vbase", vbase_o, 32'hFFFF_FF80);
        wr(12'hD08, 32'h1234_56FF);
        rd(12'hD08, d);
        check("R4 readback", d, 32'h1234_5680);
    endtask

    task automatic t_reset_key();
        logic [31:0] d;
        wr(12'hD0C, 32'h05FB_0004);
        check("R5 bad key", pulses, 0);
        wr(12'hD0C, 32'h05FA_0000);
        check("R5 key no bit", pulses, 0);
        wr(12'hD0C, 32'h05FA_0004);
        check("R5 good key", pulses, 6'b000001);
        @(posedge clk); #1;
        check("R5 single", cur_pulses(), 0);
        rd(12'hD0C, d);
        check("R5 read zero", d, 0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(12'hD18, 32'h4433_2211);
        wr(12'hD1C, 32'h8877_6655);
        wr(12'hD20, 32'hAABB_CCDD);
        check("R6 prio bus", prio_o, 96'hAABBCCDD_88776655_44332211);
        check("R6 byte0", prio_o[7:0], 8'h11);
        rd(12'hD1C, d);
        check("R6 readback", d, 32'h8877_6655);
    endtask

    task automatic t_hcs_read();
        logic [31:0] d;
        act_i = 7'b1010101; pend_i = 4'b0101;
        rd(12'hD24, d);
        check("R7 pattern a", d, 32'h0000_5909);
        act_i = 7'b0101010; pend_i = 4'b1010;
        rd(12'hD24, d);
        check("R7 pattern b", d, 32'h0000_A482);
        act_i = '0; pend_i = '0;
    endtask

    task automatic t_hcs_write();
        logic [31:0] d;
        wr(12'hD24, 32'hFFFF_FFFF);
        check("R8 enables", fault_en_o, 3'b111);
        rd(12'hD24, d);
        check("R8 readonly bits", d, 32'h0007_0000);
        wr(12'hD24, 32'h0002_0000);
        check("R8 bus only", fault_en_o, 3'b010);
    endtask

    task automatic t_ictl_read();
        logic [31:0] d;
        sys_pend_i = 3'b101; pend_vec_i = 9'h1A3;
        rd(12'hD04, d);
        check("R9 ictl", d, 32'h841A_3000);
        sys_pend_i = 3'b010; pend_vec_i = 9'h001;
        rd(12'hD04, d);
        check("R9 ictl b", d, 32'h1000_1000);
        sys_pend_i = '0; pend_vec_i = '0;
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [95:0] p0;
        logic [31:0] v0;
        logic [2:0]  e0;
        p0 = prio_o; v0 = vbase_o; e0 = fault_en_o;
        wr(12'hD10, 32'hFFFF_FFFF);
        check("R10 no pulse", pulses, 0);
        check("R10 prio kept", prio_o, p0);
        check("R10 vbase kept", vbase_o, v0);
        check("R10 en kept", fault_en_o, e0);
        rd(12'hD10, d);
        check("R10 read zero", d, 0);
        rd(12'h000, d);
        check("R10 read zero b", d, 0);
    endtask

    initial begin
        #800000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
        act_i = '0; pend_i = '0; sys_pend_i = '0; pend_vec_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_nmi();
        t_sv();
        t_tick();
        t_vbase();
        t_reset_key();
        t_prio();
        t_hcs_read();
        t_hcs_write();
        t_ictl_read();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule